// File: doc/BRIEF.md
# Flash Request Handshake Controller

This block stands in for a flash macro behind a flash protocol controller. It accepts read, page-erase and bank-erase requests. Each accepted request gets a one-cycle acknowledge, and a one-cycle completion pulse follows some time later. The storage is emulated in registers: one bank holding a data partition and a set of info partitions, all with the same page size. Reads finish on the cycle after the acknowledge. Erases take a parameterized number of cycles.

After reset the block runs an initialization phase and holds off every request until that phase ends. An erase that is in progress can be suspended. The suspend request is acknowledged when suspension starts. The erase then ends with a normal completion pulse and leaves the array untouched. Only one transaction is outstanding at any time.

Top module: `flash_hs_ctrl`

## Requirements
- R1: After reset `init_busy_o` is high and stays high for INIT_CYCLES rising edges, then stays low. No request is acknowledged while it is high. A request raised during that phase is acknowledged in the cycle after `init_busy_o` falls.
- R2: `ack_o` is a one-cycle pulse. It appears in the cycle after the clock edge at which an idle, initialized block sees a request. No further request is acknowledged before the completion of the current one. `ack_o` and `done_o` are never high together.
- R3: A read raises `done_o` for one cycle, exactly one cycle after its `ack_o`.
- R4: `rd_data_o` carries the addressed word only in the `done_o` cycle of a read, and is zero in every other cycle.
- R5: After reset, the word at flat index i holds 2^(DATA_W-1) + i. The address is {page, word}, with the word in the low log2(WORDS_PER_PAGE) bits. For the data partition (`info_part_i`=0) the flat index is page*WORDS_PER_PAGE + word. For info type t it is DATA_PAGES*WORDS_PER_PAGE + (t*INFO_PAGES + page)*WORDS_PER_PAGE + word.
- R6: An erase raises `done_o` exactly ERASE_CYCLES cycles after its `ack_o`, unless it is suspended.
- R7: A completed page erase sets every word of the addressed page (data or info) to all ones and leaves all other words unchanged.
- R8: A completed bank erase sets every data-partition word to all ones, ignores the address and partition inputs, and leaves the info partitions unchanged.
- R9: When `suspend_i` is high at an edge during an erase that is not completing at that edge, `ack_o` pulses in the next cycle. `done_o` follows SUSPEND_CYCLES cycles after that pulse, and the array is left unchanged.
- R10: `suspend_i` has no effect while no erase is running: no `ack_o` and no `done_o` result.
- R11: An address whose page lies outside its partition (info page >= INFO_PAGES) still completes the handshake. A read of it returns zero and an erase of it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Read request, held until acknowledged |
| page_erase_i | input | 1 | Page erase request, held until acknowledged |
| bank_erase_i | input | 1 | Bank erase request, held until acknowledged |
| suspend_i | input | 1 | Erase suspend request, held until acknowledged |
| addr_i | input | ADDR_W | {page, word} address |
| info_part_i | input | 1 | 0 selects the data partition, 1 the info partitions |
| info_type_i | input | TYPE_W | Info partition type |
| ack_o | output | 1 | Request or suspend accepted |
| done_o | output | 1 | Transaction complete |
| rd_data_o | output | DATA_W | Read data, valid with a read completion |
| init_busy_o | output | 1 | Initialization in progress |

## Verification
The bench keeps the default geometry: four data pages, two info types of two pages each, and four 16-bit words per page. It shortens the timing to INIT_CYCLES=6, ERASE_CYCLES=12 and SUSPEND_CYCLES=4. With these values every word can be read back after each erase. Info pages 2 and 3 are reachable through the page field, which exercises the out-of-range path. The short erase window lets a suspend land mid-erase within a few cycles and lets a request be queued across the whole initialization phase.

// File: rtl/fhc_pkg.sv
`timescale 1ns/1ps
package fhc_pkg;

  typedef enum logic [1:0] {
    FHC_IDLE  = 2'd0,
    FHC_READ  = 2'd1,
    FHC_ERASE = 2'd2,
    FHC_SUSP  = 2'd3
  } fhc_state_e;

  function automatic int fhc_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to index n items, never below one
  function automatic int fhc_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fhc_init_timer.sv
`timescale 1ns/1ps
module fhc_init_timer import fhc_pkg::*; #(
  parameter int INIT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic busy_o
);

  localparam int CW = fhc_bits(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  assign cnt_en = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (cnt_q == LAST) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  AST_INIT_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o); // R1

endmodule

// File: rtl/fhc_decode.sv
`timescale 1ns/1ps
module fhc_decode #(
  parameter int DATA_PAGES = 4,
  parameter int INFO_PAGES = 2,
  parameter int INFO_TYPES = 2,
  parameter int ADDR_W     = 4,
  parameter int TYPE_W     = 1,
  parameter int WORD_BITS  = 2,
  parameter int PAGE_IDX_W = 3
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  info_part_i,
  input  logic [TYPE_W-1:0]     info_type_i,
  output logic [PAGE_IDX_W-1:0] page_idx_o,
  output logic [WORD_BITS-1:0]  word_idx_o,
  output logic                  hit_o
);

  always_comb begin
    int pg;
    int ty;
    int flat_pg;
    pg         = int'(addr_i[ADDR_W-1:WORD_BITS]);
    ty         = int'(info_type_i);
    word_idx_o = addr_i[WORD_BITS-1:0];
    if (!info_part_i) begin
      hit_o   = (pg < DATA_PAGES);
      flat_pg = pg;
    end else begin
      hit_o   = (pg < INFO_PAGES) && (ty < INFO_TYPES);
      flat_pg = DATA_PAGES + ty * INFO_PAGES + pg;
    end
    if (!hit_o) begin
      flat_pg = 0;
    end
    page_idx_o = PAGE_IDX_W'(flat_pg);
  end

endmodule

// File: rtl/fhc_array.sv
`timescale 1ns/1ps
module fhc_array #(
  parameter int WORDS_PER_PAGE = 4,
  parameter int DATA_PAGES     = 4,
  parameter int TOTAL_PAGES    = 8,
  parameter int PAGE_IDX_W     = 3,
  parameter int IDX_W          = 5,
  parameter int DATA_W         = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [DATA_W-1:0]     rd_word_o,
  input  logic                  pg_clr_i,
  input  logic [PAGE_IDX_W-1:0] pg_clr_idx_i,
  input  logic                  bank_clr_i
);

  localparam int NUM_WORDS  = TOTAL_PAGES * WORDS_PER_PAGE;
  localparam int DATA_WORDS = DATA_PAGES * WORDS_PER_PAGE;

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    localparam int PAGE_NO = gi / WORDS_PER_PAGE;
    localparam bit IN_DATA = (gi < DATA_WORDS);
    localparam logic [DATA_W-1:0] RST_VAL = {1'b1, (DATA_W-1)'(gi)};

    logic              clr_en;
    logic [DATA_W-1:0] word_q;

    assign clr_en = (pg_clr_i && (pg_clr_idx_i == PAGE_IDX_W'(PAGE_NO)))
                  || (bank_clr_i && IN_DATA);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= RST_VAL;
      end else if (clr_en) begin
        word_q <= '1;
      end
    end

    assign words[gi] = word_q;
  end

  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        rd_word_o = words[i];
      end
    end
  end

endmodule

// File: rtl/fhc_seq.sv
`timescale 1ns/1ps
module fhc_seq import fhc_pkg::*; #(
  parameter int ERASE_CYCLES   = 20,
  parameter int SUSPEND_CYCLES = 5,
  parameter int PAGE_IDX_W     = 3,
  parameter int WORD_BITS      = 2,
  parameter int DATA_W         = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            busy_i,
  input  logic                            rd_req_i,
  input  logic                            page_erase_i,
  input  logic                            bank_erase_i,
  input  logic                            suspend_i,
  input  logic [PAGE_IDX_W-1:0]           page_idx_i,
  input  logic [WORD_BITS-1:0]            word_idx_i,
  input  logic                            hit_i,
  input  logic [DATA_W-1:0]               rd_word_i,
  output logic [PAGE_IDX_W+WORD_BITS-1:0] rd_idx_o,
  output logic                            pg_clr_o,
  output logic [PAGE_IDX_W-1:0]           pg_clr_idx_o,
  output logic                            bank_clr_o,
  output logic                            ack_o,
  output logic                            done_o,
  output logic [DATA_W-1:0]               rd_data_o
);

  localparam int CNT_W = fhc_bits(fhc_max(ERASE_CYCLES, SUSPEND_CYCLES) + 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SUSP_LAST  = CNT_W'(SUSPEND_CYCLES - 1);

  fhc_state_e            state_q, state_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [PAGE_IDX_W-1:0] page_q;
  logic [WORD_BITS-1:0]  word_q;
  logic                  hit_q, bank_q;
  logic                  ack_q, ack_d;
  logic                  done_q, done_d;
  logic [DATA_W-1:0]     rdat_q, rdat_d;
  logic                  accept;
  logic                  erase_end;

  assign accept = (state_q == FHC_IDLE) && !busy_i
                && (rd_req_i || page_erase_i || bank_erase_i);
  assign erase_end = (state_q == FHC_ERASE) && (cnt_q == ERASE_LAST);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    ack_d      = 1'b0;
    done_d     = 1'b0;
    rdat_d     = '0;
    pg_clr_o   = 1'b0;
    bank_clr_o = 1'b0;
    unique case (state_q)
      FHC_IDLE: begin
        if (accept) begin
          ack_d   = 1'b1;
          cnt_d   = '0;
          state_d = rd_req_i ? FHC_READ : FHC_ERASE;
        end
      end
      FHC_READ: begin
        done_d  = 1'b1;
        rdat_d  = hit_q ? rd_word_i : '0;
        state_d = FHC_IDLE;
      end
      FHC_ERASE: begin
        if (erase_end) begin
          done_d     = 1'b1;
          state_d    = FHC_IDLE;
          bank_clr_o = bank_q;
          pg_clr_o   = !bank_q && hit_q;
        end else if (suspend_i) begin
          ack_d   = 1'b1;
          cnt_d   = '0;
          state_d = FHC_SUSP;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      FHC_SUSP: begin
        if (cnt_q == SUSP_LAST) begin
          done_d  = 1'b1;
          state_d = FHC_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = FHC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FHC_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
      rdat_q  <= rdat_d;
    end
  end

  // request fields captured once, at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      word_q <= '0;
      hit_q  <= 1'b0;
      bank_q <= 1'b0;
    end else if (accept) begin
      page_q <= page_idx_i;
      word_q <= word_idx_i;
      hit_q  <= hit_i;
      bank_q <= !rd_req_i && !page_erase_i;
    end
  end

  assign rd_idx_o     = {page_q, word_q};
  assign pg_clr_idx_o = page_q;
  assign ack_o        = ack_q;
  assign done_o       = done_q;
  assign rd_data_o    = rdat_q;

  AST_ACK_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && done_o)); // R2
  AST_NO_ACK_IN_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !ack_o); // R1
  AST_RD_DATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (rd_data_o == '0)); // R4
  AST_SUSP_KEEPS_ARRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FHC_SUSP) |-> !(pg_clr_o || bank_clr_o)); // R9

endmodule

// File: rtl/flash_hs_ctrl.sv
`timescale 1ns/1ps
module flash_hs_ctrl import fhc_pkg::*; #(
  parameter int WORDS_PER_PAGE = 4,
  parameter int DATA_PAGES     = 4,
  parameter int INFO_PAGES     = 2,
  parameter int INFO_TYPES     = 2,
  parameter int DATA_W         = 16,
  parameter int INIT_CYCLES    = 8,
  parameter int ERASE_CYCLES   = 20,
  parameter int SUSPEND_CYCLES = 5,
  localparam int WORD_BITS     = fhc_bits(WORDS_PER_PAGE),
  localparam int ADDR_W        = fhc_bits(fhc_max(DATA_PAGES, INFO_PAGES)) + WORD_BITS,
  localparam int TYPE_W        = fhc_bits(INFO_TYPES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              page_erase_i,
  input  logic              bank_erase_i,
  input  logic              suspend_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              info_part_i,
  input  logic [TYPE_W-1:0] info_type_i,
  output logic              ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              init_busy_o
);

  localparam int TOTAL_PAGES = DATA_PAGES + INFO_TYPES * INFO_PAGES;
  localparam int PAGE_IDX_W  = fhc_bits(TOTAL_PAGES);
  localparam int IDX_W       = PAGE_IDX_W + WORD_BITS;

  logic [PAGE_IDX_W-1:0] dec_page, clr_page;
  logic [WORD_BITS-1:0]  dec_word;
  logic                  dec_hit;
  logic [IDX_W-1:0]      rd_idx;
  logic [DATA_W-1:0]     rd_word;
  logic                  pg_clr, bank_clr;
  logic                  busy;

  fhc_init_timer #(
    .INIT_CYCLES (INIT_CYCLES)
  ) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (busy)
  );

  fhc_decode #(
    .DATA_PAGES (DATA_PAGES),
    .INFO_PAGES (INFO_PAGES),
    .INFO_TYPES (INFO_TYPES),
    .ADDR_W     (ADDR_W),
    .TYPE_W     (TYPE_W),
    .WORD_BITS  (WORD_BITS),
    .PAGE_IDX_W (PAGE_IDX_W)
  ) u_dec (
    .addr_i      (addr_i),
    .info_part_i (info_part_i),
    .info_type_i (info_type_i),
    .page_idx_o  (dec_page),
    .word_idx_o  (dec_word),
    .hit_o       (dec_hit)
  );

  fhc_seq #(
    .ERASE_CYCLES   (ERASE_CYCLES),
    .SUSPEND_CYCLES (SUSPEND_CYCLES),
    .PAGE_IDX_W     (PAGE_IDX_W),
    .WORD_BITS      (WORD_BITS),
    .DATA_W         (DATA_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy),
    .rd_req_i     (rd_req_i),
    .page_erase_i (page_erase_i),
    .bank_erase_i (bank_erase_i),
    .suspend_i    (suspend_i),
    .page_idx_i   (dec_page),
    .word_idx_i   (dec_word),
    .hit_i        (dec_hit),
    .rd_word_i    (rd_word),
    .rd_idx_o     (rd_idx),
    .pg_clr_o     (pg_clr),
    .pg_clr_idx_o (clr_page),
    .bank_clr_o   (bank_clr),
    .ack_o        (ack_o),
    .done_o       (done_o),
    .rd_data_o    (rd_data_o)
  );

  fhc_array #(
    .WORDS_PER_PAGE (WORDS_PER_PAGE),
    .DATA_PAGES     (DATA_PAGES),
    .TOTAL_PAGES    (TOTAL_PAGES),
    .PAGE_IDX_W     (PAGE_IDX_W),
    .IDX_W          (IDX_W),
    .DATA_W         (DATA_W)
  ) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_idx_i     (rd_idx),
    .rd_word_o    (rd_word),
    .pg_clr_i     (pg_clr),
    .pg_clr_idx_i (clr_page),
    .bank_clr_i   (bank_clr)
  );

  assign init_busy_o = busy;

endmodule

// File: tb/flash_hs_ctrl_test.sv
`timescale 1ns/1ps
module flash_hs_ctrl_test;

  localparam int WPP = 4, DP = 4, IP = 2, IT = 2, DW = 16;
  localparam int INIT = 6, ER = 12, SU = 4;
  localparam int DWORDS = DP * WPP;
  localparam int NW = DWORDS + IT * IP * WPP;

  logic clk = 1'b0;
  logic rst_n;
  logic rd, pe, be, sus, part;
  logic [3:0] addr;
  logic itype;
  logic ack, done, busy;
  logic [DW-1:0] rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_hs_ctrl #(
    .WORDS_PER_PAGE (WPP), .DATA_PAGES (DP), .INFO_PAGES (IP), .INFO_TYPES (IT),
    .DATA_W (DW), .INIT_CYCLES (INIT), .ERASE_CYCLES (ER), .SUSPEND_CYCLES (SU)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .rd_req_i (rd), .page_erase_i (pe),
    .bank_erase_i (be), .suspend_i (sus), .addr_i (addr), .info_part_i (part),
    .info_type_i (itype), .ack_o (ack), .done_o (done), .rd_data_o (rdata),
    .init_busy_o (busy)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // flat index of a word per R5, -1 when the page is outside its partition (R11)
  function automatic int flat_of(bit p, int ty, int pg, int wd);
    if (!p) return (pg < DP) ? pg * WPP + wd : -1;
    return (pg < IP && ty < IT) ? DWORDS + (ty * IP + pg) * WPP + wd : -1;
  endfunction

  function automatic int init_val(int i);
    return (1 << (DW - 1)) + i;
  endfunction

  // behavioural reference, stepped on every rising edge
  int  arr [NW];
  int  m_st, m_cnt, m_icnt, m_idx;
  bit  m_busy, m_bank;
  logic e_ack, e_done;
  logic [DW-1:0] e_rd;

  always @(posedge clk) begin
    bit busy_pre;
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) arr[i] = init_val(i);
      m_st = 0; m_cnt = 0; m_icnt = 0; m_idx = 0; m_busy = 1; m_bank = 0;
      e_ack = 0; e_done = 0; e_rd = '0;
    end else begin
      busy_pre = m_busy;
      e_ack = 0; e_done = 0; e_rd = '0;
      if (m_busy) begin
        m_icnt++;
        if (m_icnt == INIT) m_busy = 0;
      end
      case (m_st)
        0: if (!busy_pre && (rd || pe || be)) begin
             e_ack = 1;
             m_idx = flat_of(part, int'(itype), int'(addr) / WPP, int'(addr) % WPP);
             m_cnt = 0;
             if (rd) m_st = 1;
             else begin m_st = 2; m_bank = !pe; end
           end
        1: begin
             e_done = 1;
             e_rd = (m_idx >= 0) ? DW'(arr[m_idx]) : '0;
             m_st = 0;
           end
        2: if (m_cnt == ER - 1) begin
             e_done = 1; m_st = 0;
             if (m_bank) begin
               for (int i = 0; i < DWORDS; i++) arr[i] = 16'hFFFF;
             end else if (m_idx >= 0) begin
               for (int i = 0; i < WPP; i++) arr[m_idx - m_idx % WPP + i] = 16'hFFFF;
             end
           end else if (sus) begin
             e_ack = 1; m_st = 3; m_cnt = 0;
           end else m_cnt++;
        default: if (m_cnt == SU - 1) begin
             e_done = 1; m_st = 0;
           end else m_cnt++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy === m_busy, "R1 init_busy per cycle", busy, m_busy);
      chk(ack === e_ack, "R2 ack per cycle", ack, e_ack);
      chk(done === e_done, "R3 done per cycle", done, e_done);
      chk(rdata === e_rd, "R4 rd_data per cycle", rdata, e_rd);
    end
  end

  task automatic xact(input int kind, input bit p, input int ty, input int pg, input int wd,
                      input int sus_at, output int n_done, output int n_sack,
                      output logic [DW-1:0] data);
    int n;
    bit got;
    @(negedge clk);
    addr = 4'(pg * WPP + wd); part = p; itype = 1'(ty);
    rd = (kind == 0); pe = (kind == 1); be = (kind == 2);
    got = 0;
    while (!got) begin
      @(negedge clk);
      if (ack) got = 1;
    end
    rd = 0; pe = 0; be = 0;
    n = 0; n_done = 0; n_sack = 0; data = '0;
    while (n_done == 0) begin
      @(negedge clk);
      n++;
      if (ack) begin
        if (n_sack == 0 && sus) n_sack = n;
        else chk(1'b0, "R2 second ack before done", 1, 0);
        sus = 0;
      end
      if (done) begin n_done = n; data = rdata; end
      if (n == sus_at) sus = 1;
    end
  endtask

  task automatic rd_chk(input bit p, input int ty, input int pg, input int wd,
                        input int exp, input string tag);
    int nd, ns;
    logic [DW-1:0] d;
    xact(0, p, ty, pg, wd, -1, nd, ns, d);
    chk(nd == 1, {tag, " read latency"}, nd, 1);
    chk(d == DW'(exp), {tag, " read data"}, d, exp);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    int nd, ns, nb, nn;
    bit acked;
    logic [DW-1:0] d;
    rst_n = 0; rd = 0; pe = 0; be = 0; sus = 0; part = 0; addr = '0; itype = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b1, "R1 busy in reset", busy, 1);
    chk(ack === 1'b0 && done === 1'b0, "R2 quiet in reset", ack, 0);
    chk(rdata === '0, "R4 rd_data zero in reset", rdata, 0);

    // R1: request queued across the whole init phase (data page 3 word 2)
    rst_n = 1; rd = 1; part = 0; addr = 4'(3 * WPP + 2);
    nb = 0; nn = 0; acked = 0;
    while (!acked) begin
      @(negedge clk);
      nn++;
      if (busy) nb++;
      if (ack) begin
        acked = 1;
        chk(!busy, "R1 no ack while busy", busy, 0);
      end
    end
    rd = 0;
    chk(nb == INIT - 1, "R1 busy cycles after release", nb, INIT - 1);
    chk(nn == INIT + 1, "R1 ack one cycle after busy falls", nn, INIT + 1);
    @(negedge clk);
    chk(done === 1'b1 && rdata == DW'(init_val(14)), "R3 first read", rdata, init_val(14));

    // R5: reset contents across partitions
    rd_chk(0, 0, 0, 0, init_val(flat_of(0, 0, 0, 0)), "R5 data p0w0");
    rd_chk(0, 0, 3, 3, init_val(flat_of(0, 0, 3, 3)), "R5 data p3w3");
    rd_chk(1, 0, 1, 2, init_val(flat_of(1, 0, 1, 2)), "R5 info t0p1w2");
    rd_chk(1, 1, 0, 1, init_val(flat_of(1, 1, 0, 1)), "R5 info t1p0w1");
    // R11: info page beyond range
    rd_chk(1, 0, 2, 0, 0, "R11 out-of-range read");

    // R6, R7: data page erase
    xact(1, 0, 0, 1, 2, -1, nd, ns, d);
    chk(nd == ER, "R6 page erase latency", nd, ER);
    for (int w = 0; w < WPP; w++) rd_chk(0, 0, 1, w, 16'hFFFF, "R7 erased data page");
    rd_chk(0, 0, 0, 3, init_val(3), "R7 neighbour below kept");
    rd_chk(0, 0, 2, 0, init_val(8), "R7 neighbour above kept");

    // R7: info page erase
    xact(1, 1, 1, 1, 0, -1, nd, ns, d);
    chk(nd == ER, "R6 info erase latency", nd, ER);
    rd_chk(1, 1, 1, 3, 16'hFFFF, "R7 erased info page");
    rd_chk(1, 0, 1, 3, init_val(flat_of(1, 0, 1, 3)), "R7 other info type kept");

    // R11: erase of a page outside the info partition
    xact(1, 1, 0, 3, 0, -1, nd, ns, d);
    chk(nd == ER, "R11 out-of-range erase completes", nd, ER);
    rd_chk(1, 0, 1, 0, init_val(flat_of(1, 0, 1, 0)), "R11 array unchanged");

    // R9: suspend mid-erase on data page 2
    xact(1, 0, 0, 2, 0, 3, nd, ns, d);
    chk(ns == 4, "R9 suspend ack cycle", ns, 4);
    chk(nd == 4 + SU, "R9 suspend done cycle", nd, 4 + SU);
    rd_chk(0, 0, 2, 1, init_val(9), "R9 suspended page kept");

    // R10: suspend with nothing running
    @(negedge clk);
    sus = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!ack && !done, "R10 idle suspend ignored", {ack, done}, 0);
    end
    sus = 0;

    // R8: bank erase, address inputs point at an info page
    xact(2, 1, 0, 0, 1, -1, nd, ns, d);
    chk(nd == ER, "R8 bank erase latency", nd, ER);
    rd_chk(0, 0, 0, 0, 16'hFFFF, "R8 data p0 erased");
    rd_chk(0, 0, 3, 3, 16'hFFFF, "R8 data p3 erased");
    rd_chk(1, 0, 0, 1, init_val(flat_of(1, 0, 0, 1)), "R8 info kept");
    rd_chk(1, 1, 1, 0, 16'hFFFF, "R8 earlier info erase kept");

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule